// File: doc/BRIEF.md
# Re-Reference Counter Replacement Unit

This block holds the replacement state for every set of an N-way set-associative cache and names the way to evict when a miss needs space. Each way of each set owns a small re-reference counter. The cache controller reports hits and fills as one-cycle event strobes carrying a set index and a way. It asks for a victim through a valid/ready request channel and receives the chosen way on a valid/ready response channel. Tag and data arrays live outside the block.

A static policy pin chooses between two behaviours. The first is a one-bit not-recently-used scheme: a touched way is marked recent, and once every way in a set is marked recent the whole set is marked stale again. The second is a multi-bit re-reference scheme in which a freshly filled line is placed one step away from eviction, so a line that is never reused leaves quickly. A line that is hit is moved to the far end. When no way of a set holds the eviction value, every counter of that set ages by the same amount until one does.

Back-pressure: a request is taken on a cycle where both `vreq_valid` and `vreq_ready` are high. The answer appears on the next cycle and stays, unchanged, until `rsp_ready` is high. `vreq_ready` is low only while an answer waits unaccepted. The requester must not drop or change a request while `vreq_ready` is low. The policy pin may change only while reset is held.

Top module: `rrip_repl_unit`

## Requirements
- R1: After reset every counter of every set holds its all-ones value (7 for 3-bit counters), `rsp_valid` is 0, and the first victim answer for any set is way 0.
- R2: With `mode_multi` = 0, a hit or a fill to a way clears that way's state to 0 ("recently used").
- R3: With `mode_multi` = 0, when clearing a way would leave every way of the set at 0, every way of that set is set to 1 instead, including the way just touched.
- R4: With `mode_multi` = 0, the victim is the lowest-numbered way whose state is nonzero, and a victim request leaves the state unchanged.
- R5: With `mode_multi` = 1, a fill writes the insertion value 6 (the all-ones value minus one) into the filled way.
- R6: With `mode_multi` = 1, a hit writes 0 into the hit way.
- R7: With `mode_multi` = 1, a victim request adds (7 − largest counter of the set) to every counter of the set and stores the result. The victim is the lowest-numbered way that then holds 7.
- R8: Events to one set in the same cycle are applied in a fixed order: hit first, then fill, then victim selection. A hit and a fill to the same way leave the fill's value, and a victim request sees both updates.
- R9: A request accepted on cycle k gives `rsp_valid` = 1 from cycle k+1. `rsp_way` is held stable while `rsp_valid` = 1 and `rsp_ready` = 0. `vreq_ready` = 0 exactly while a response is waiting unaccepted.
- R10: Events aimed at one set never change the state or the victim of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_multi | input | 1 | 0: one-bit recency policy; 1: multi-bit re-reference policy |
| hit_valid | input | 1 | Hit event strobe |
| hit_set | input | 4 | Set index of the hit |
| hit_way | input | 2 | Way that hit |
| fill_valid | input | 1 | Fill event strobe |
| fill_set | input | 4 | Set index of the fill |
| fill_way | input | 2 | Way being filled |
| vreq_valid | input | 1 | Victim request valid |
| vreq_ready | output | 1 | Unit can take a victim request |
| vreq_set | input | 4 | Set index for the victim request |
| rsp_valid | output | 1 | Victim answer valid |
| rsp_ready | input | 1 | Requester takes the answer |
| rsp_way | output | 2 | Way chosen for eviction |

## Verification
The properties assume that `mode_multi` is constant outside reset. They also assume a request is raised only while `vreq_ready` is high, and that set and way indices are within the configured counts. The value checks on single ways rule out cycles where a same-set victim request or a same-way fill could also write that way. The stimulus changes the policy only under reset and issues victim requests only when the unit is ready. It draws every index from the legal range, and it holds the response channel stalled only with no new request pending, so every check stays inside these assumptions.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  typedef enum logic {
    POL_RECENCY_BIT = 1'b0,
    POL_REREF_CTR   = 1'b1
  } policy_e;
endpackage

// File: rtl/rrip_access_update.sv
module rrip_access_update
  import rrip_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int CTR_W    = 3
) (
  input  policy_e                           pol,
  input  logic [NUM_WAYS-1:0][CTR_W-1:0]    cur,
  input  logic                              hit_en,
  input  logic [$clog2(NUM_WAYS)-1:0]       hit_way,
  input  logic                              fill_en,
  input  logic [$clog2(NUM_WAYS)-1:0]       fill_way,
  output logic [NUM_WAYS-1:0][CTR_W-1:0]    nxt
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INS = CTR_MAX - CTR_W'(1);

  typedef logic [NUM_WAYS-1:0][CTR_W-1:0] ctr_vec_t;

  // one-bit policy: mark recent; when the set runs out of stale ways, mark all stale
  function automatic ctr_vec_t mark_recent(ctr_vec_t v, logic [WAY_W-1:0] w);
    ctr_vec_t r;
    logic     any_stale;
    r         = v;
    r[w]      = '0;
    any_stale = 1'b0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (r[i] != '0) any_stale = 1'b1;
    end
    if (!any_stale) begin
      for (int i = 0; i < NUM_WAYS; i++) r[i] = CTR_W'(1);
    end
    return r;
  endfunction

  always_comb begin
    ctr_vec_t stage;
    stage = cur;
    // hit is applied ahead of fill
    if (hit_en) begin
      if (pol == POL_REREF_CTR) stage[hit_way] = '0;
      else                      stage = mark_recent(stage, hit_way);
    end
    if (fill_en) begin
      if (pol == POL_REREF_CTR) stage[fill_way] = CTR_INS;
      else                      stage = mark_recent(stage, fill_way);
    end
    nxt = stage;
  end
endmodule

// File: rtl/rrip_age_select.sv
module rrip_age_select
  import rrip_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int CTR_W    = 3
) (
  input  policy_e                           pol,
  input  logic [NUM_WAYS-1:0][CTR_W-1:0]    ctrs,
  output logic [NUM_WAYS-1:0][CTR_W-1:0]    aged,
  output logic [$clog2(NUM_WAYS)-1:0]       victim
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] peak;
  logic [CTR_W-1:0] delta;

  always_comb begin
    peak = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (ctrs[i] > peak) peak = ctrs[i];
    end
    delta = CTR_MAX - peak;
  end

  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (pol == POL_REREF_CTR) aged[i] = ctrs[i] + delta;
      else                      aged[i] = ctrs[i];
    end
  end

  // lowest-index priority pick over the aged state
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!found) begin
        if ((pol == POL_REREF_CTR && aged[i] == CTR_MAX) ||
            (pol == POL_RECENCY_BIT && aged[i] != '0)) begin
          victim = WAY_W'(i);
          found  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rrip_repl_unit.sv
module rrip_repl_unit
  import rrip_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CTR_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mode_multi,
  input  logic                          hit_valid,
  input  logic [$clog2(NUM_SETS)-1:0]   hit_set,
  input  logic [$clog2(NUM_WAYS)-1:0]   hit_way,
  input  logic                          fill_valid,
  input  logic [$clog2(NUM_SETS)-1:0]   fill_set,
  input  logic [$clog2(NUM_WAYS)-1:0]   fill_way,
  input  logic                          vreq_valid,
  output logic                          vreq_ready,
  input  logic [$clog2(NUM_SETS)-1:0]   vreq_set,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [$clog2(NUM_WAYS)-1:0]   rsp_way
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);

  policy_e pol;
  assign pol = policy_e'(mode_multi);

  logic [NUM_SETS-1:0][NUM_WAYS-1:0][CTR_W-1:0] ctr_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][CTR_W-1:0] post_acc;
  logic [NUM_WAYS-1:0][CTR_W-1:0]               aged_set;
  logic [WAY_W-1:0]                             pick_way;
  logic                                         vreq_fire;

  assign vreq_ready = !rsp_valid || rsp_ready;
  assign vreq_fire  = vreq_valid && vreq_ready;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    rrip_access_update #(
      .NUM_WAYS (NUM_WAYS),
      .CTR_W    (CTR_W)
    ) u_acc (
      .pol      (pol),
      .cur      (ctr_q[s]),
      .hit_en   (hit_valid && hit_set == SET_W'(s)),
      .hit_way  (hit_way),
      .fill_en  (fill_valid && fill_set == SET_W'(s)),
      .fill_way (fill_way),
      .nxt      (post_acc[s])
    );
  end

  rrip_age_select #(
    .NUM_WAYS (NUM_WAYS),
    .CTR_W    (CTR_W)
  ) u_age (
    .pol    (pol),
    .ctrs   (post_acc[vreq_set]),
    .aged   (aged_set),
    .victim (pick_way)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr_q <= '1;
    end else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (vreq_fire && vreq_set == SET_W'(s)) ctr_q[s] <= aged_set;
        else                                     ctr_q[s] <= post_acc[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_way   <= '0;
    end else if (vreq_fire) begin
      rsp_valid <= 1'b1;
      rsp_way   <= pick_way;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rrip_repl_checker.sv
module rrip_repl_checker #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CTR_W    = 3
) (
  input logic                                         clk,
  input logic                                         rst_n,
  input logic                                         mode_multi,
  input logic                                         hit_valid,
  input logic [$clog2(NUM_SETS)-1:0]                  hit_set,
  input logic [$clog2(NUM_WAYS)-1:0]                  hit_way,
  input logic                                         fill_valid,
  input logic [$clog2(NUM_SETS)-1:0]                  fill_set,
  input logic [$clog2(NUM_WAYS)-1:0]                  fill_way,
  input logic                                         vreq_valid,
  input logic                                         vreq_ready,
  input logic [$clog2(NUM_SETS)-1:0]                  vreq_set,
  input logic                                         rsp_valid,
  input logic                                         rsp_ready,
  input logic [$clog2(NUM_WAYS)-1:0]                  rsp_way,
  input logic [NUM_SETS-1:0][NUM_WAYS-1:0][CTR_W-1:0] ctr_q
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_INS = CTR_MAX - CTR_W'(1);

  logic fire;
  assign fire = vreq_valid && vreq_ready;

  logic             hit_chk_q, fill_chk_q, pick_chk_q;
  logic [SET_W-1:0] hs_q, fs_q, vs_q;
  logic [WAY_W-1:0] hw_q, fw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_chk_q  <= 1'b0;
      fill_chk_q <= 1'b0;
      pick_chk_q <= 1'b0;
      hs_q <= '0; fs_q <= '0; vs_q <= '0; hw_q <= '0; fw_q <= '0;
    end else begin
      hit_chk_q  <= mode_multi && hit_valid
                    && !(fill_valid && fill_set == hit_set && fill_way == hit_way)
                    && !(fire && vreq_set == hit_set);
      fill_chk_q <= mode_multi && fill_valid && !(fire && vreq_set == fill_set);
      pick_chk_q <= mode_multi && fire;
      hs_q <= hit_set;  hw_q <= hit_way;
      fs_q <= fill_set; fw_q <= fill_way;
      vs_q <= vreq_set;
    end
  end

  assert_hit_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_chk_q |-> ctr_q[hs_q][hw_q] == '0);

  assert_fill_inserts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_chk_q |-> ctr_q[fs_q][fw_q] == CTR_INS);

  assert_victim_at_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pick_chk_q |-> ctr_q[vs_q][rsp_way] == CTR_MAX);

  assert_rsp_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_way)));

  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_nz
    assert_set_never_all_recent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_multi |-> ctr_q[s] != '0);
  end
endmodule

bind rrip_repl_unit rrip_repl_checker #(
  .NUM_SETS (NUM_SETS),
  .NUM_WAYS (NUM_WAYS),
  .CTR_W    (CTR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_multi (mode_multi),
  .hit_valid  (hit_valid),
  .hit_set    (hit_set),
  .hit_way    (hit_way),
  .fill_valid (fill_valid),
  .fill_set   (fill_set),
  .fill_way   (fill_way),
  .vreq_valid (vreq_valid),
  .vreq_ready (vreq_ready),
  .vreq_set   (vreq_set),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_way    (rsp_way),
  .ctr_q      (ctr_q)
);

// File: tb/rrip_repl_unit_tb_top.sv
module rrip_repl_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_multi = 1'b0;
  logic       hit_valid = 1'b0;
  logic [3:0] hit_set = '0;
  logic [1:0] hit_way = '0;
  logic       fill_valid = 1'b0;
  logic [3:0] fill_set = '0;
  logic [1:0] fill_way = '0;
  logic       vreq_valid = 1'b0;
  logic       vreq_ready;
  logic [3:0] vreq_set = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [1:0] rsp_way;

  always #(CLK_PERIOD/2) clk = ~clk;

  rrip_repl_unit #(.NUM_SETS(NS), .NUM_WAYS(NW), .CTR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi),
    .hit_valid(hit_valid), .hit_set(hit_set), .hit_way(hit_way),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
    .vreq_valid(vreq_valid), .vreq_ready(vreq_ready), .vreq_set(vreq_set),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_way(rsp_way)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  int    exp_q[$];
  string tag_q[$];
  int    mdl[NS][NW];

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic void m_reset();
    for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) mdl[s][w] = 7;
  endfunction

  function automatic void m_recent(int s, int w);
    bit any;
    mdl[s][w] = 0;
    any = 0;
    for (int i = 0; i < NW; i++) if (mdl[s][i] != 0) any = 1;
    if (!any) for (int i = 0; i < NW; i++) mdl[s][i] = 1;
  endfunction

  function automatic int m_pick(int s);
    int mx = 0;
    if (mode_multi) begin
      for (int i = 0; i < NW; i++) if (mdl[s][i] > mx) mx = mdl[s][i];
      for (int i = 0; i < NW; i++) mdl[s][i] += 7 - mx;
      for (int i = 0; i < NW; i++) if (mdl[s][i] == 7) return i;
    end else begin
      for (int i = 0; i < NW; i++) if (mdl[s][i] != 0) return i;
    end
    return 0;
  endfunction

  // driver: one cycle of events; expected answer goes to the scoreboard
  task automatic drive(bit hv, int hs, int hw, bit fv, int fs, int fw,
                       bit rv, int rs, string req);
    @(negedge clk);
    hit_valid  = hv; hit_set  = 4'(hs); hit_way  = 2'(hw);
    fill_valid = fv; fill_set = 4'(fs); fill_way = 2'(fw);
    vreq_valid = rv; vreq_set = 4'(rs);
    if (hv) begin
      if (mode_multi) mdl[hs][hw] = 0; else m_recent(hs, hw);
    end
    if (fv) begin
      if (mode_multi) mdl[fs][fw] = 6; else m_recent(fs, fw);
    end
    if (rv) begin
      exp_q.push_back(m_pick(rs));
      tag_q.push_back(req);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic do_reset(bit multi);
    @(negedge clk);
    rst_n = 1'b0;
    mode_multi = multi;
    hit_valid = 0; fill_valid = 0; vreq_valid = 0; rsp_ready = 1;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
    chk(vreq_ready == 1'b1, "R9", int'(vreq_ready), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on every accepted answer
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9", int'(rsp_way), -1);
      end else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(int'(rsp_way) == e, t, int'(rsp_way), e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int held;
    // ---------------- one-bit policy ----------------
    do_reset(1'b0);
    drive(0,0,0, 0,0,0, 1,3, "R1");                 // fresh set -> way 0
    drive(1,3,0, 0,0,0, 0,0, "R2");
    drive(1,3,1, 0,0,0, 0,0, "R2");
    drive(0,0,0, 0,0,0, 1,3, "R2");                 // ways 0,1 recent -> 2
    drive(1,3,2, 0,0,0, 0,0, "R3");
    drive(1,3,3, 0,0,0, 0,0, "R3");                 // all recent -> all stale
    drive(0,0,0, 0,0,0, 1,3, "R3");                 // -> way 0
    drive(0,0,0, 0,0,0, 1,3, "R4");                 // pick leaves state: 0 again
    drive(1,5,0, 0,0,0, 1,5, "R8");                 // same-cycle hit first -> 1
    drive(0,0,0, 1,5,1, 0,0, "R2");                 // fill marks recent
    drive(0,0,0, 0,0,0, 1,5, "R2");                 // -> 2
    drive(0,0,0, 0,0,0, 1,6, "R10");                // untouched set -> 0
    drive(1,9,0, 1,9,1, 1,9, "R8");
    for (int i = 0; i < 300; i++)
      drive($urandom_range(0,1), $urandom_range(0,15), $urandom_range(0,3),
            $urandom_range(0,1), $urandom_range(0,15), $urandom_range(0,3),
            $urandom_range(0,1), $urandom_range(0,15), "R4");
    idle(4);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);

    // ---------------- multi-bit policy ----------------
    do_reset(1'b1);
    drive(0,0,0, 0,0,0, 1,1, "R1");                 // all 7 -> way 0
    for (int w = 0; w < NW; w++) drive(0,0,0, 1,1,w, 0,0, "R5");
    drive(0,0,0, 0,0,0, 1,1, "R7");                 // all 6 age to 7 -> 0
    drive(1,1,0, 0,0,0, 0,0, "R6");
    drive(0,0,0, 0,0,0, 1,1, "R6");                 // way0 at 0 -> 1
    drive(1,2,2, 1,2,2, 0,0, "R8");                 // fill wins -> 6
    drive(1,2,0, 0,0,0, 0,0, "R8");
    drive(1,2,1, 0,0,0, 0,0, "R8");
    drive(0,0,0, 0,0,0, 1,2, "R8");                 // 0,0,6,7 -> 3
    drive(1,4,0, 0,0,0, 1,4, "R8");                 // hit applied first -> 1
    for (int w = 0; w < NW; w++) drive(1,7,w, 0,0,0, 0,0, "R6");
    drive(0,0,0, 1,7,2, 0,0, "R5");
    drive(0,0,0, 0,0,0, 1,7, "R7");                 // 0,0,6,0 -> +1 -> 2
    drive(0,0,0, 0,0,0, 1,7, "R7");                 // unchanged -> 2
    drive(0,0,0, 0,0,0, 1,8, "R10");
    idle(2);

    // back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(0,0,0, 0,0,0, 1,7, "R9");
    drive(1,7,2, 0,0,0, 0,0, "R9");                 // hit during stall
    idle(1);
    held = exp_q[0];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(rsp_valid == 1'b1, "R9", int'(rsp_valid), 1);
      chk(vreq_ready == 1'b0, "R9", int'(vreq_ready), 0);
      chk(int'(rsp_way) == held, "R9", int'(rsp_way), held);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    idle(2);
    chk(vreq_ready == 1'b1, "R9", int'(vreq_ready), 1);

    for (int i = 0; i < 300; i++)
      drive($urandom_range(0,1), $urandom_range(0,15), $urandom_range(0,3),
            $urandom_range(0,1), $urandom_range(0,15), $urandom_range(0,3),
            $urandom_range(0,1), $urandom_range(0,15), "R7");
    idle(4);
    chk(exp_q.size() == 0, "R9", exp_q.size(), 0);
    finish_run();
  end
endmodule